// File: doc/BRIEF.md
# Cumulative-Boundary Raster Timing Generator

This block produces the raster timing for a parallel RGB panel: a horizontal sync pulse, a vertical sync pulse and a data-enable strobe, each with its own selectable polarity. Software does not program porch widths one by one. It programs, per axis, the last pixel (or line) index of four nested phases: the end of sync, the end of back porch, the end of active video and the end of the whole line (or frame). Each boundary equals the running total of the phases up to it, minus one. A pixel counter runs against the horizontal boundaries, and a line counter advances once per line and runs against the vertical ones.

The block also reports where the raster is. A packed position word gives the current pixel and line. Four phase flags show which phases are in progress. A sticky line-match flag is raised when the raster reaches a programmed line. That flag is cleared by a write-one-to-clear command and is gated onto an interrupt request by an enable bit. Configuration arrives through a plain word write port and takes effect on the next clock.

Top module: `disp_timing_gen`

## Requirements
- R1: After reset, and whenever the run bit (control word 4, bit 0) is low, both counters are 0 and remain 0. The position word and phase flags read 0, and hsync, vsync and de sit at their inactive levels.
- R2: While running, the pixel counter starts at 0 in the first cycle after the run bit is set. It increments once per clock. In the cycle after it equals the horizontal total boundary, it returns to 0, and the line counter advances by one at that point.
- R3: The line counter returns to 0 on the line wrap that occurs while it equals the vertical total boundary.
- R4: Horizontal sync is active for pixel indices 0 through the sync boundary, which is the sync width minus 1. Vertical sync is active for line indices 0 through the vertical sync boundary.
- R5: Horizontal data-enable covers pixel indices from the back-porch boundary plus 1 up to and including the active boundary. Vertical data-enable follows the same rule for lines. The de output is active only when both are active.
- R6: Control word 4 sets polarity: bit 1 for hsync, bit 2 for vsync, bit 3 for de, with 1 meaning active high and 0 meaning active low. Bit 4 is presented unchanged on pclk_inv_o.
- R7: phase_o is active-high whatever the polarity setting: bit 0 is vertical data-enable, bit 1 is horizontal data-enable, bit 2 is vertical sync and bit 3 is horizontal sync.
- R8: pos_o holds the current pixel index in bits 31:16 and the current line index in bits 15:0.
- R9: Word 5 bits 11:0 set the match line. One cycle after the raster is at pixel 0 of that line, line_flag_o goes high, and it stays high until a write to word 7 with bit 0 set. A write to word 7 with bit 0 clear has no effect.
- R10: irq_o equals line_flag_o gated by the interrupt enable, which is bit 0 of word 6.
- R11: Boundary words 0 to 3 hold, in that order, the sync, back-porch, active and total boundaries. Each word carries the horizontal value in bits 27:16 and the vertical value in bits 11:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | Configuration word index |
| cfg_wdata | input | 32 | Configuration write data |
| hsync_o | output | 1 | Horizontal sync, polarity applied |
| vsync_o | output | 1 | Vertical sync, polarity applied |
| de_o | output | 1 | Data enable, polarity applied |
| pclk_inv_o | output | 1 | Pixel clock inversion select |
| pos_o | output | 32 | Current pixel (31:16) and line (15:0) |
| phase_o | output | 4 | Active-high phase flags |
| line_flag_o | output | 1 | Sticky line-match flag |
| irq_o | output | 1 | Line-match interrupt request |

## Verification
The embedded properties cover counter behaviour on every cycle. The counters must hold at zero while stopped, step by exactly one below the total boundary, and return to zero once the total is reached. They also check that the line flag stays set until it is cleared and that the interrupt never fires while disabled. Only the bench scenarios can show the things that depend on a whole raster pattern. These are the exact pixel and line windows of sync and data-enable, how the polarity bits map to each pin, the position packing, and the line and cycle on which the match flag appears.

// File: rtl/dtg_pkg.sv
// Shared types for the raster timing generator.
// Assumes the counter width does not exceed 16 bits (position packing).
package dtg_pkg;
    localparam int CW = 12;

    typedef struct packed {
        logic [CW-1:0] x;
        logic [CW-1:0] y;
    } dtg_pair_t;

    typedef struct packed {
        dtg_pair_t     sync_end;
        dtg_pair_t     bp_end;
        dtg_pair_t     act_end;
        dtg_pair_t     total;
        logic          run;
        logic          hs_pol;
        logic          vs_pol;
        logic          de_pol;
        logic          pclk_pol;
        logic [CW-1:0] match_line;
        logic          irq_en;
    } dtg_cfg_t;
endpackage

// File: rtl/dtg_regs.sv
// Configuration register file. A write to a word takes effect on the next
// clock. Word 7 holds no state: a write with bit 0 set emits a one-cycle
// clear pulse. Assumes CW <= 16 so a horizontal field fits in bits 16 upward.
module dtg_regs
    import dtg_pkg::*;
#(
    parameter int AW = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [31:0]   wdata,
    output dtg_cfg_t      cfg,
    output logic          clr_pulse
);
    localparam int XLSB = 16;

    function automatic dtg_pair_t unpack_pair(input logic [31:0] d);
        dtg_pair_t p;
        p.x = d[XLSB +: CW];
        p.y = d[0 +: CW];
        return p;
    endfunction

    // Purpose: capture configuration words on write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg <= '0;
        end else if (we) begin
            case (addr)
                3'd0: cfg.sync_end <= unpack_pair(wdata);
                3'd1: cfg.bp_end   <= unpack_pair(wdata);
                3'd2: cfg.act_end  <= unpack_pair(wdata);
                3'd3: cfg.total    <= unpack_pair(wdata);
                3'd4: begin
                    cfg.run      <= wdata[0];
                    cfg.hs_pol   <= wdata[1];
                    cfg.vs_pol   <= wdata[2];
                    cfg.de_pol   <= wdata[3];
                    cfg.pclk_pol <= wdata[4];
                end
                3'd5: cfg.match_line <= wdata[CW-1:0];
                3'd6: cfg.irq_en     <= wdata[0];
                default: ;
            endcase
        end
    end

    // Purpose: decode the write-one-to-clear command.
    always_comb clr_pulse = we && (addr == 3'd7) && wdata[0];
endmodule

// File: rtl/dtg_axis_counter.sv
// One raster axis counter. It counts 0..limit, advancing on step, and wraps
// to 0 after the limit. It holds at 0 while run is low. The wrap output
// marks a step taken at the limit and chains the next axis.
module dtg_axis_counter #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic         step,
    input  logic [W-1:0] limit,
    output logic [W-1:0] count,
    output logic         wrap
);
    // Purpose: flag the step that leaves the last index of the axis.
    always_comb wrap = run && step && (count >= limit);

    // Purpose: advance, wrap or hold the axis position.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)
            count <= '0;
        else if (wrap)
            count <= '0;
        else if (step)
            count <= count + 1'b1;
    end

    p_hold_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> count == '0);
    // R2 / R3: wrap after the total boundary
    p_wrap_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && count == limit) |=> count == '0);
    p_step_one_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (run && step && count < limit) |=> count == $past(count) + 1'b1);
endmodule

// File: rtl/dtg_axis_phase.sv
// Phase decode for one axis. Sync spans 0..sync_end, and the active window
// spans bp_end+1..act_end, both inclusive. It assumes the boundaries are
// programmed in ascending order.
module dtg_axis_phase #(
    parameter int W = 12
) (
    input  logic [W-1:0] count,
    input  logic [W-1:0] sync_end,
    input  logic [W-1:0] bp_end,
    input  logic [W-1:0] act_end,
    output logic         in_sync,
    output logic         in_active
);
    // Purpose: compare the position against the cumulative boundaries.
    always_comb begin
        in_sync   = (count <= sync_end);
        in_active = (count > bp_end) && (count <= act_end);
    end
endmodule

// File: rtl/dtg_line_irq.sv
// Sticky line-match flag. It is set one cycle after the raster sits at
// pixel 0 of the match line while running, and cleared by the clear pulse.
// A set on the same cycle as a clear wins.
module dtg_line_irq #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         run,
    input  logic [W-1:0] xpos,
    input  logic [W-1:0] ypos,
    input  logic [W-1:0] match_line,
    input  logic         clr,
    output logic         flag
);
    logic hit;

    // Purpose: detect the start of the match line.
    always_comb hit = run && (xpos == '0) && (ypos == match_line);

    // Purpose: hold the flag until it is cleared by software.
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (hit) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !clr) |=> flag);
endmodule

// File: rtl/disp_timing_gen.sv
// Raster timing generator top. It chains a pixel counter and a line counter
// and decodes the phases of each axis against cumulative boundaries. It
// applies the output polarities and publishes position, phase flags and the
// line interrupt. Outputs are combinational from registered state.
module disp_timing_gen
    import dtg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    output logic        hsync_o,
    output logic        vsync_o,
    output logic        de_o,
    output logic        pclk_inv_o,
    output logic [31:0] pos_o,
    output logic [3:0]  phase_o,
    output logic        line_flag_o,
    output logic        irq_o
);
    localparam int NAX = 2;     // axis 0 = pixels, axis 1 = lines
    localparam int PW  = 16;    // position field width

    dtg_cfg_t        cfg;
    logic            clr_pulse;
    logic [CW-1:0]   cnt   [NAX];
    logic [NAX-1:0]  wrap;
    logic [NAX-1:0]  step;
    logic [NAX-1:0]  sync_a;
    logic [NAX-1:0]  act_a;
    logic [CW-1:0]   lim   [NAX];
    logic [CW-1:0]   s_end [NAX];
    logic [CW-1:0]   b_end [NAX];
    logic [CW-1:0]   a_end [NAX];

    dtg_regs #(.AW(3)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .cfg      (cfg),
        .clr_pulse(clr_pulse)
    );

    // Purpose: route each axis's boundaries and step source.
    always_comb begin
        lim[0] = cfg.total.x;    lim[1] = cfg.total.y;
        s_end[0] = cfg.sync_end.x; s_end[1] = cfg.sync_end.y;
        b_end[0] = cfg.bp_end.x;   b_end[1] = cfg.bp_end.y;
        a_end[0] = cfg.act_end.x;  a_end[1] = cfg.act_end.y;
        step[0] = 1'b1;
        step[1] = wrap[0];
    end

    for (genvar a = 0; a < NAX; a++) begin : g_axis
        dtg_axis_counter #(.W(CW)) u_cnt (
            .clk  (clk),
            .rst_n(rst_n),
            .run  (cfg.run),
            .step (step[a]),
            .limit(lim[a]),
            .count(cnt[a]),
            .wrap (wrap[a])
        );
        dtg_axis_phase #(.W(CW)) u_phase (
            .count    (cnt[a]),
            .sync_end (s_end[a]),
            .bp_end   (b_end[a]),
            .act_end  (a_end[a]),
            .in_sync  (sync_a[a]),
            .in_active(act_a[a])
        );
    end

    dtg_line_irq #(.W(CW)) u_irq (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cfg.run),
        .xpos      (cnt[0]),
        .ypos      (cnt[1]),
        .match_line(cfg.match_line),
        .clr       (clr_pulse),
        .flag      (line_flag_o)
    );

    logic hs_on, vs_on, de_on;

    // Purpose: form the active-high phases, forced idle when stopped.
    always_comb begin
        hs_on = cfg.run && sync_a[0];
        vs_on = cfg.run && sync_a[1];
        de_on = cfg.run && act_a[0] && act_a[1];
        phase_o = {hs_on, vs_on, cfg.run && act_a[0], cfg.run && act_a[1]};
    end

    // Purpose: apply the per-pin polarity to the panel outputs.
    always_comb begin
        hsync_o    = cfg.hs_pol ? hs_on : ~hs_on;
        vsync_o    = cfg.vs_pol ? vs_on : ~vs_on;
        de_o       = cfg.de_pol ? de_on : ~de_on;
        pclk_inv_o = cfg.pclk_pol;
    end

    // Purpose: pack position and gate the interrupt request.
    always_comb begin
        pos_o = cfg.run ? {{(PW-CW){1'b0}}, cnt[0], {(PW-CW){1'b0}}, cnt[1]} : '0;
        irq_o = line_flag_o && cfg.irq_en;
    end

    p_irq_gated_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (line_flag_o && cfg.irq_en));
    p_line_after_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.run && wrap[0] && !wrap[1]) |=> cnt[0] == '0);
endmodule

// File: tb/disp_timing_gen_tb.sv
module disp_timing_gen_tb;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cfg_we;
    logic [2:0]  cfg_addr;
    logic [31:0] cfg_wdata;
    logic        hsync_o, vsync_o, de_o, pclk_inv_o, line_flag_o, irq_o;
    logic [31:0] pos_o;
    logic [3:0]  phase_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit fexp   = 1'b0;   // expected line flag

    // test geometry: 10 pixels per line, 5 lines per frame
    localparam int HSE = 1, HBE = 3, HAE = 7, HTOT = 9;
    localparam int VSE = 0, VBE = 1, VAE = 3, VTOT = 4;
    localparam int MLINE = 2;

    always #2 clk = ~clk;   // 250 MHz

    disp_timing_gen u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .hsync_o(hsync_o), .vsync_o(vsync_o),
        .de_o(de_o), .pclk_inv_o(pclk_inv_o), .pos_o(pos_o),
        .phase_o(phase_o), .line_flag_o(line_flag_o), .irq_o(irq_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at cycle %0d", req, act, exp, cycles);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(posedge clk);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    function automatic logic [31:0] pair(input int x, input int y);
        return (32'(x) << 16) | 32'(y);
    endfunction

    // R1: reset state with default (active-low) polarity
    task automatic t_reset;
        rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 hsync idle", 32'(hsync_o), 32'd1);
        chk("R1 vsync idle", 32'(vsync_o), 32'd1);
        chk("R1 de idle", 32'(de_o), 32'd1);
        chk("R1 pos zero", pos_o, 32'd0);
        chk("R1 phase zero", 32'(phase_o), 32'd0);
        chk("R10 irq zero", 32'(irq_o), 32'd0);
    endtask

    // R11: boundary programming (enable written separately)
    task automatic t_program;
        wr(3'd0, pair(HSE, VSE));
        wr(3'd1, pair(HBE, VBE));
        wr(3'd2, pair(HAE, VAE));
        wr(3'd3, pair(HTOT, VTOT));
        wr(3'd5, 32'(MLINE));
    endtask

    // R2..R10: walk the raster from the first running cycle
    task automatic t_scan(input int n, input bit hp, input bit vp, input bit dp,
                          input bit pp, input bit ie);
        for (int k = 0; k < n; k++) begin
            int h = k % (HTOT + 1);
            int v = (k / (HTOT + 1)) % (VTOT + 1);
            bit hs  = (h <= HSE);
            bit vs  = (v <= VSE);
            bit hde = (h > HBE) && (h <= HAE);
            bit vde = (v > VBE) && (v <= VAE);
            chk("R4 R6 hsync", 32'(hsync_o), 32'(hp ? hs : !hs));
            chk("R4 R6 vsync", 32'(vsync_o), 32'(vp ? vs : !vs));
            chk("R5 R6 de", 32'(de_o), 32'(dp ? (hde && vde) : !(hde && vde)));
            chk("R7 phase", 32'(phase_o), 32'({hs, vs, hde, vde}));
            chk("R2 R3 R8 pos", pos_o, pair(h, v));
            chk("R9 line flag", 32'(line_flag_o), 32'(fexp));
            chk("R10 irq", 32'(irq_o), 32'(fexp && ie));
            chk("R6 pclk sel", 32'(pclk_inv_o), 32'(pp));
            @(negedge clk);
            if (h == 0 && v == MLINE) fexp = 1'b1;
        end
    endtask

    // R1: stopping forces idle levels and holds counters
    task automatic t_stop(input bit pol_hi);
        wr(3'd4, pol_hi ? 32'h1E : 32'h0);
        for (int i = 0; i < 4; i++) begin
            chk("R1 stop hsync", 32'(hsync_o), 32'(!pol_hi));
            chk("R1 stop de", 32'(de_o), 32'(!pol_hi));
            chk("R1 stop pos", pos_o, 32'd0);
            @(negedge clk);
        end
    endtask

    // R9 R10: clear semantics and interrupt gating
    task automatic t_irq;
        chk("R9 flag set before clear", 32'(line_flag_o), 32'd1);
        wr(3'd7, 32'h0);
        chk("R9 zero write ignored", 32'(line_flag_o), 32'd1);
        chk("R10 irq masked", 32'(irq_o), 32'd0);
        wr(3'd6, 32'h1);
        chk("R10 irq enabled", 32'(irq_o), 32'd1);
        wr(3'd7, 32'h1);
        chk("R9 flag cleared", 32'(line_flag_o), 32'd0);
        chk("R10 irq dropped", 32'(irq_o), 32'd0);
        fexp = 1'b0;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired actual=%0d expected<20000", cycles);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_program();
        wr(3'd4, 32'h1F);                 // run, all active high, pclk invert
        t_scan(120, 1, 1, 1, 1, 0);       // R2 R3 R4 R5 R7 R8 R9
        t_stop(1'b1);
        t_irq();
        wr(3'd4, 32'h15);                 // run, hs low, vs high, de low, pclk invert
        t_scan(60, 0, 1, 0, 1, 1);        // R6 polarity mix, R10 live irq
        t_stop(1'b0);
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule